// File: doc/BRIEF.md
# Directed Rounding Correction Unit

This unit sits behind a floating-point datapath whose hardware rounds only to nearest or toward zero. When software asks for rounding toward plus or minus infinity, such a datapath gives a result that is one step short in magnitude whenever the exact value was not representable. The unit fixes this. It takes the packed result, held as a high and a low 32-bit word, and adds one to the raw integer encoding when the sign and the requested direction call for it. In IEEE encodings, adding one to the encoding moves the value one unit in the last place away from zero.

Three result layouts are supported. A single-precision result lives in the low word. A double-precision result spans both words. A paired-single result carries two independent values, one per word. The unit acts only when the operation reported an inexact result and was not a compare. Every other result passes through untouched. The corrected result is registered and appears one clock after the input is accepted.

Top module: `dirround_fix`

## Requirements
- R1: `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low.
- R2: With `rmode` 2'b00 (nearest) or 2'b01 (toward zero), both output words equal the input words.
- R3: With `rmode` 2'b10 (toward plus infinity), a result whose governing sign bit is 0 is incremented by one as an integer, and a result whose sign bit is 1 is unchanged.
- R4: With `rmode` 2'b11 (toward minus infinity), a result whose governing sign bit is 1 is incremented by one as an integer, and a result whose sign bit is 0 is unchanged.
- R5: With `fmt` 2'b00 (single), the governing sign is bit 31 of the low word. Only the low word is incremented, modulo 2^32, and the high word passes unchanged.
- R6: With `fmt` 2'b01 (double), the governing sign is bit 31 of the high word. The 64-bit value {high,low} is incremented, so a carry out of the low word enters the high word.
- R7: With `fmt` 2'b10 (paired), each word is corrected on its own, using its own bit 31 as sign. A wrap of the low word never alters the high word.
- R8: With `is_cmp` high, both output words equal the input words.
- R9: With `inexact` low, both output words equal the input words.
- R10: With `fmt` 2'b11 (reserved), both output words equal the input words.
- R11: While `rst_n` is low at a clock edge, `out_valid`, `out_hi` and `out_lo` are cleared to zero.
- R12: In a cycle with `in_valid` low, `out_hi` and `out_lo` keep their previous values whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input result is present this cycle |
| in_hi | input | 32 | High word of the packed result |
| in_lo | input | 32 | Low word of the packed result |
| fmt | input | 2 | Layout: 00 single, 01 double, 10 paired, 11 reserved |
| rmode | input | 2 | Rounding mode: 00 nearest, 01 zero, 10 plus infinity, 11 minus infinity |
| inexact | input | 1 | The producing operation reported an inexact result |
| is_cmp | input | 1 | The producing operation was a compare |
| out_valid | output | 1 | Corrected result is present |
| out_hi | output | 32 | Corrected high word |
| out_lo | output | 32 | Corrected low word |

## Verification
The sweep crosses every mode, layout, inexact and compare setting with word patterns built to sit on boundaries: all ones in the low word, the largest positive and negative encodings, and both signed zeros. An all-ones low word with a positive high word under plus-infinity rounding separates the layouts. A design that drops the 64-bit carry leaves the double high word stale. A design that lets the carry cross lanes corrupts the paired high word. A design that increments the single high word changes a word it should leave alone. Picking the sign from the wrong word shows up in double mode whenever the two words differ in bit 31, and a design that ignores the inexact or compare gates corrects results it must leave unchanged.

// File: rtl/dirround_fix_pkg.sv
// Package: shared encodings for the directed rounding correction unit.
// Assumes a two-bit mode field and a two-bit layout field as listed below.
package dirround_fix_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_TOZERO  = 2'b01,
        RM_UP      = 2'b10,
        RM_DOWN    = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        FMT_SINGLE = 2'b00,
        FMT_DOUBLE = 2'b01,
        FMT_PAIRED = 2'b10,
        FMT_RSVD   = 2'b11
    } fmt_e;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/dirround_fix_dec.sv
// Module: decides whether one value must be bumped by one encoding step.
// Assumes the caller has already folded every gating condition into 'active';
// only the two directed modes can ever request a bump.
module dirround_fix_dec
    import dirround_fix_pkg::*;
(
    input  logic       active,
    input  logic [1:0] rmode,
    input  logic       sign,
    output logic       bump
);

    // Bump when the rounding direction points away from zero for this sign.
    always_comb begin
        bump = 1'b0;
        if (active) begin
            case (rmode)
                RM_UP:   bump = ~sign;
                RM_DOWN: bump = sign;
                default: bump = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/dirround_fix_inc.sv
// Module: adds a one-bit carry-in to a word, wrapping modulo 2^W.
// Assumes any carry-out is derived by the caller from the operand pattern.
module dirround_fix_inc #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] y
);

    // Single ripple of the carry-in through the word.
    always_comb begin
        y = a + {{(W-1){1'b0}}, cin};
    end

endmodule

// File: rtl/dirround_fix.sv
// Module: directed rounding correction unit (top).
// Corrects a packed result produced with nearest/zero rounding so that it
// meets plus- or minus-infinity rounding, by adding one to the raw encoding.
// Assumes the layout field selects single (low word), double (both words,
// one 64-bit value) or paired (two independent words). Output is registered.
module dirround_fix
    import dirround_fix_pkg::*;
#(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_hi,
    input  logic [WORD_W-1:0] in_lo,
    input  logic [1:0]        fmt,
    input  logic [1:0]        rmode,
    input  logic              inexact,
    input  logic              is_cmp,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_hi,
    output logic [WORD_W-1:0] out_lo
);

    localparam int unsigned SIGN_BIT = WORD_W - 1;

    logic              corr_en;
    logic              is_double;
    logic              is_paired;
    logic              lo_sign;
    logic              lo_bump;
    logic              hi_bump_own;
    logic              lo_carry;
    logic [WORD_W-1:0] lane_in   [LANES];
    logic              lane_cin  [LANES];
    logic [WORD_W-1:0] lane_sum  [LANES];

    // Gate: only inexact, non-compare results in a directed mode and a known layout.
    always_comb begin
        is_double = (fmt == FMT_DOUBLE);
        is_paired = (fmt == FMT_PAIRED);
        corr_en   = inexact && !is_cmp && rmode[1] && (fmt != FMT_RSVD);
        lo_sign   = is_double ? in_hi[SIGN_BIT] : in_lo[SIGN_BIT];
    end

    dirround_fix_dec u_dec_lo (
        .active (corr_en),
        .rmode  (rmode),
        .sign   (lo_sign),
        .bump   (lo_bump)
    );

    dirround_fix_dec u_dec_hi (
        .active (corr_en && is_paired),
        .rmode  (rmode),
        .sign   (in_hi[SIGN_BIT]),
        .bump   (hi_bump_own)
    );

    // Carry chain: the low word feeds the high word only for a double result.
    always_comb begin
        lo_carry    = lo_bump && (&in_lo);
        lane_in[0]  = in_lo;
        lane_in[1]  = in_hi;
        lane_cin[0] = lo_bump;
        lane_cin[1] = is_double ? lo_carry : hi_bump_own;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dirround_fix_inc #(.W(WORD_W)) u_inc (
            .a   (lane_in[g]),
            .cin (lane_cin[g]),
            .y   (lane_sum[g])
        );
    end

    // Output register: capture corrected words on valid, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hi    <= '0;
            out_lo    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_lo <= lane_sum[0];
                out_hi <= lane_sum[1];
            end
        end
    end

endmodule

// File: rtl/dirround_fix_chk.sv
// Module: property checker for dirround_fix, attached by bind.
// Assumes the port encodings documented with the top module.
module dirround_fix_chk #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_hi,
    input logic [WORD_W-1:0] in_lo,
    input logic [1:0]        fmt,
    input logic [1:0]        rmode,
    input logic              inexact,
    input logic              is_cmp,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_hi,
    input logic [WORD_W-1:0] out_lo
);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2
    nondirected_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !rmode[1]) |=> (out_hi == $past(in_hi) && out_lo == $past(in_lo)));

    // R8
    compare_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_cmp) |=> (out_hi == $past(in_hi) && out_lo == $past(in_lo)));

    // R9
    exact_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !inexact) |=> (out_hi == $past(in_hi) && out_lo == $past(in_lo)));

    // R10
    reserved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'b11) |=> (out_hi == $past(in_hi) && out_lo == $past(in_lo)));

    // R5
    single_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'b00) |=> (out_hi == $past(in_hi)));

    // R6
    double_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'b01) |=>
        (({out_hi, out_lo} - $past({in_hi, in_lo})) <= 64'd1));

    // R7
    paired_no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'b10 && rmode == 2'b10 && in_hi[WORD_W-1]) |=>
        (out_hi == $past(in_hi)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_hi) && $stable(out_lo)));

endmodule

bind dirround_fix dirround_fix_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_hi     (in_hi),
    .in_lo     (in_lo),
    .fmt       (fmt),
    .rmode     (rmode),
    .inexact   (inexact),
    .is_cmp    (is_cmp),
    .out_valid (out_valid),
    .out_hi    (out_hi),
    .out_lo    (out_lo)
);

// File: tb/sim_dirround_fix.sv
`timescale 1ns/1ps
module sim_dirround_fix;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_hi = '0;
    logic [31:0] in_lo = '0;
    logic [1:0]  fmt = '0;
    logic [1:0]  rmode = '0;
    logic        inexact = 1'b0;
    logic        is_cmp = 1'b0;
    logic        out_valid;
    logic [31:0] out_hi;
    logic [31:0] out_lo;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dirround_fix u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hi(in_hi), .in_lo(in_lo),
        .fmt(fmt), .rmode(rmode), .inexact(inexact), .is_cmp(is_cmp),
        .out_valid(out_valid), .out_hi(out_hi), .out_lo(out_lo)
    );

    function automatic logic [31:0] pat(int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h3F80_0000;
            6: return 32'hBF80_0000;
            default: return 32'h7F7F_FFFF;
        endcase
    endfunction

    // Expected result computed from the requirements.
    function automatic logic [63:0] model(logic [31:0] h, logic [31:0] l, logic [1:0] f,
                                          logic [1:0] m, logic inx, logic cmp);
        logic [63:0] r;
        logic up;
        r = {h, l};
        if (!inx || cmp || !m[1] || f == 2'b11) return r;
        up = (m == 2'b10);
        case (f)
            2'b00: r[31:0] = l + {31'd0, up ^ l[31]};
            2'b01: r = {h, l} + {63'd0, up ^ h[31]};
            default: begin
                r[31:0]  = l + {31'd0, up ^ l[31]};
                r[63:32] = h + {31'd0, up ^ h[31]};
            end
        endcase
        return r;
    endfunction

    function automatic string tag(logic [1:0] f, logic [1:0] m, logic inx, logic cmp);
        if (cmp) return "R8";
        if (!inx) return "R9";
        if (!m[1]) return "R2";
        if (f == 2'b11) return "R10";
        return $sformatf("%s %s", (m == 2'b10) ? "R3" : "R4",
                         (f == 2'b00) ? "R5" : (f == 2'b01) ? "R6" : "R7");
    endfunction

    task automatic check(string req, logic [64:0] act, logic [64:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        logic [63:0] last;
        // R11: reset clears outputs while inputs are active
        in_valid = 1'b1; in_hi = 32'h1234_5678; in_lo = 32'h9ABC_DEF0;
        rmode = 2'b10; inexact = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", {out_valid, out_hi, out_lo}, 65'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        last = '0;
        // Sweep: modes x layouts x gates x boundary word patterns
        for (int m = 0; m < 4; m++)
            for (int f = 0; f < 4; f++)
                for (int x = 0; x < 2; x++)
                    for (int c = 0; c < 2; c++)
                        for (int hi = 0; hi < 8; hi++)
                            for (int lo = 0; lo < 8; lo++) begin
                                in_valid = 1'b1;
                                in_hi = pat(hi); in_lo = pat(lo);
                                fmt = 2'(f); rmode = 2'(m);
                                inexact = x[0]; is_cmp = c[0];
                                last = model(pat(hi), pat(lo), 2'(f), 2'(m), x[0], c[0]);
                                @(negedge clk);
                                // R1 valid one cycle later, plus data per tag
                                check({tag(2'(f), 2'(m), x[0], c[0]), " R1"},
                                      {out_valid, out_hi, out_lo}, {1'b1, last});
                            end
        // R12: idle cycle with a correctable pattern leaves outputs held
        in_valid = 1'b0; in_hi = 32'h0000_0000; in_lo = 32'hFFFF_FFFF;
        fmt = 2'b01; rmode = 2'b10; inexact = 1'b1; is_cmp = 1'b0;
        @(negedge clk);
        check("R12 R1", {out_valid, out_hi, out_lo}, {1'b0, last});
        @(negedge clk);
        check("R12", {out_valid, out_hi, out_lo}, {1'b0, last});
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule